// File: doc/BRIEF.md
# Pin-Triggered RAM Clear Controller

This block wipes a small user RAM to all ones in response to a falling edge on an external, asynchronous clear pin, provided software has armed it through a clear-enable bit. The pin passes through a two-stage synchronizer. A detected falling edge then starts a sweep that writes the fill value to each address in turn, one byte per clock, over the block's own RAM write port. When the sweep ends, a sticky completion flag is set. That flag can pull an active-low interrupt output when interrupts are enabled and the main supply is present.

From the detected edge, a lockout output blocks host register access for a fixed number of cycles. The lockout always lasts longer than the sweep itself. No other storage is addressed by the block. The sweep proceeds whether or not the main supply is reported present. An external interrupt request input is merged into the interrupt output so that other pending sources keep it low.

Top module: `ramclr_top`

## Requirements
- R1: A falling edge on `clr_pin_n` while control bit 0 (clear enable) is 1 makes the block write 0xFF to addresses 0 through 113, one per clock in ascending order. `ram_we` is first high, with address 0, after the third rising clock edge that follows the pin falling.
- R2: While the clear-enable bit is 0, a falling edge on `clr_pin_n` produces no RAM write, raises no lockout and leaves the completion flag unchanged.
- R3: Control bit 2 (completion flag) becomes 1 on the clock edge that follows the write to address 113. It stays 1 until a host write carries 0 in bit 2. A host write carrying 1 in bit 2 never sets it.
- R4: `irq_n` is low while the completion flag is 1, control bit 1 (interrupt enable) is 1 and `supply_ok` is 1. `irq_n` returns high once the flag is cleared, unless another source is pending.
- R5: While `other_irq` is 1, `irq_n` is low regardless of the completion flag.
- R6: `host_lock` is high for exactly RECOVER_CYC clock cycles, starting in the cycle of the first RAM write of a sweep. It therefore covers the whole sweep.
- R7: While `host_lock` is high, host register writes are discarded and `host_rdata` reads 0.
- R8: A new falling edge on the pin during a sweep is ignored. The sweep neither restarts nor lengthens, and exactly 114 writes occur.
- R9: With `supply_ok` at 0 the sweep still runs and the completion flag still sets, but `irq_n` stays high unless `other_irq` is 1.
- R10: After reset the control register reads 0, `ram_we` and `host_lock` are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_pin_n | input | 1 | Asynchronous clear pin, active on a falling edge |
| supply_ok | input | 1 | Main supply present |
| other_irq | input | 1 | Another interrupt source is pending |
| host_wr | input | 1 | Host control register write strobe |
| host_wdata | input | 3 | Write data: bit 0 clear enable, bit 1 interrupt enable, bit 2 completion flag (write 0 to clear) |
| host_rdata | output | 3 | Control register read data, same bit layout, 0 while locked |
| host_lock | output | 1 | Host access lockout |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 7 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a second pin edge and a host write that both arrive while a sweep is in flight. The bench reaches it by counting cycles from the first observed write. It raises and drops the pin again twenty and forty cycles into the sweep, then tries to disarm the block through the register port ten cycles later. The scoreboard must still see exactly the 114 ascending writes queued at the start. The lock window must measure exactly RECOVER_CYC, and the enable bit must survive the attempted write.

// File: rtl/ramclr_pkg.sv
package ramclr_pkg;
   // Control register layout; the bench decodes these bit positions.
   localparam int unsigned CTRL_W = 3;
   typedef struct packed {
      logic done;    // bit 2
      logic irq_en;  // bit 1
      logic clr_en;  // bit 0
   } ctrl_t;
endpackage

// File: rtl/ramclr_sync_edge.sv
module ramclr_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ramclr_sync_edge: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= pin_n;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain_q[STAGES-1];
   end

   assign fall = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/ramclr_sweep.sv
module ramclr_sweep #(
   parameter int unsigned NUM_BYTES = 114,
   parameter int unsigned ADDR_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic [ADDR_W-1:0] addr,
   output logic              finish
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_BYTES - 1);

   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         addr_q <= '0;
      end else if (busy_q) begin
         if (addr_q == LAST) begin
            busy_q <= 1'b0;
            addr_q <= '0;
         end else begin
            addr_q <= addr_q + 1'b1;
         end
      end else if (start) begin
         busy_q <= 1'b1;
         addr_q <= '0;
      end
   end

   assign busy   = busy_q;
   assign addr   = addr_q;
   assign finish = busy_q && (addr_q == LAST);
endmodule

// File: rtl/ramclr_lockout.sv
module ramclr_lockout #(
   parameter int unsigned RECOVER_CYC = 130
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic lock
);
   localparam int unsigned CNT_W = $clog2(RECOVER_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(RECOVER_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign lock = (cnt_q != '0);
endmodule

// File: rtl/ramclr_top.sv
module ramclr_top
   import ramclr_pkg::*;
#(
   parameter int unsigned NUM_BYTES   = 114,
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned RECOVER_CYC = 130,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_pin_n,
   input  logic              supply_ok,
   input  logic              other_irq,
   input  logic              host_wr,
   input  logic [2:0]        host_wdata,
   output logic [2:0]        host_rdata,
   output logic              host_lock,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              irq_n
);
   localparam logic [DATA_W-1:0] FILL = '1;

   generate
      if (NUM_BYTES > (1 << ADDR_W)) begin : g_bad_addr
         $error("ramclr_top: ADDR_W too narrow for NUM_BYTES");
      end
      if (RECOVER_CYC < NUM_BYTES) begin : g_bad_recover
         $error("ramclr_top: RECOVER_CYC must cover the sweep");
      end
      if (CTRL_W != 3) begin : g_bad_ctrl
         $error("ramclr_top: control register width mismatch");
      end
   endgenerate

   ctrl_t ctrl_q;
   ctrl_t wr_val;
   logic  pin_fall, sweep_busy, sweep_finish, sweep_start, lock;

   ramclr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(clr_pin_n), .fall(pin_fall)
   );

   assign sweep_start = pin_fall & ctrl_q.clr_en & ~sweep_busy;

   ramclr_sweep #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_sweep (
      .clk(clk), .rst_n(rst_n), .start(sweep_start),
      .busy(sweep_busy), .addr(ram_addr), .finish(sweep_finish)
   );

   ramclr_lockout #(.RECOVER_CYC(RECOVER_CYC)) u_lock (
      .clk(clk), .rst_n(rst_n), .start(sweep_start), .lock(lock)
   );

   assign wr_val = ctrl_t'(host_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (host_wr && !lock) begin
            ctrl_q.clr_en <= wr_val.clr_en;
            ctrl_q.irq_en <= wr_val.irq_en;
            if (!wr_val.done) ctrl_q.done <= 1'b0;
         end
         if (sweep_finish) ctrl_q.done <= 1'b1;
      end
   end

   assign host_rdata = lock ? 3'b000 : 3'(ctrl_q);
   assign host_lock  = lock;
   assign ram_we     = sweep_busy;
   assign ram_wdata  = FILL;
   assign irq_n      = ~((ctrl_q.done & ctrl_q.irq_en & supply_ok) | other_irq);
endmodule

// File: rtl/ramclr_chk.sv
module ramclr_chk #(
   parameter int unsigned NUM_BYTES = 114,
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned DATA_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              supply_ok,
   input logic              other_irq,
   input logic              host_lock,
   input logic              ram_we,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [DATA_W-1:0] ram_wdata,
   input logic              irq_n,
   input logic              done_q,
   input logic              en_q
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_BYTES - 1);

   p_start_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we) |-> ram_addr == '0);
   p_ascend_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && $past(ram_we)) |-> ram_addr == $past(ram_addr) + 1'b1);
   p_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (ram_addr <= LAST && ram_wdata == '1));
   p_armed_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we) |-> $past(en_q));
   p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> ($past(ram_we) && $past(ram_addr) == LAST));
   p_lock_covers_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> host_lock);
   p_quiet_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!supply_ok && !other_irq) |-> irq_n);
   p_other_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      other_irq |-> !irq_n);
endmodule

bind ramclr_top ramclr_chk #(
   .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .other_irq(other_irq),
   .host_lock(host_lock), .ram_we(ram_we), .ram_addr(ram_addr),
   .ram_wdata(ram_wdata), .irq_n(irq_n),
   .done_q(ctrl_q.done), .en_q(ctrl_q.clr_en)
);

// File: tb/tb_ramclr_top.sv
`timescale 1ns/1ps
module tb_ramclr_top;
   localparam int NB = 114;
   localparam int RC = 130;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_pin_n = 1'b1;
   logic       supply_ok = 1'b1;
   logic       other_irq = 1'b0;
   logic       host_wr = 1'b0;
   logic [2:0] host_wdata = '0;
   logic [2:0] host_rdata;
   logic       host_lock, ram_we, irq_n;
   logic [6:0] ram_addr;
   logic [7:0] ram_wdata;

   int checks = 0;
   int errors = 0;
   int writes_seen = 0;
   int lock_cycles = 0;
   int exp_q[$];

   always #2.5 clk = ~clk;

   ramclr_top dut (
      .clk(clk), .rst_n(rst_n), .clr_pin_n(clr_pin_n), .supply_ok(supply_ok),
      .other_irq(other_irq), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_lock(host_lock), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .irq_n(irq_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Monitor: pops expected addresses as writes appear (R1, R8, R2).
   always @(negedge clk) begin
      if (rst_n && host_lock) lock_cycles++;
      if (rst_n && ram_we) begin
         writes_seen++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected RAM write at address", int'(ram_addr), -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(ram_addr) == e, "R1", "write address", int'(ram_addr), e);
            chk(ram_wdata == 8'hFF, "R1", "write data", int'(ram_wdata), 255);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      finish_run();
   end

   task automatic host_write(input logic [2:0] v);
      host_wr = 1'b1; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic push_sweep();
      for (int a = 0; a < NB; a++) exp_q.push_back(a);
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      // R10 reset state
      chk(host_rdata == 3'b000, "R10", "rdata after reset", int'(host_rdata), 0);
      chk(!ram_we && !host_lock, "R10", "we/lock after reset", int'({ram_we, host_lock}), 0);
      chk(irq_n == 1'b1, "R10", "irq_n after reset", int'(irq_n), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 disabled: pin edge does nothing
      host_write(3'b000);
      clr_pin_n = 1'b0;
      repeat (10) @(negedge clk);
      chk(writes_seen == 0, "R2", "writes while disabled", writes_seen, 0);
      chk(!host_lock && host_rdata == 3'b000, "R2", "lock/flag while disabled",
          int'({host_lock, host_rdata}), 0);
      clr_pin_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1/R6/R7/R8/R3/R4 main sweep
      host_write(3'b011);
      lock_cycles = 0;
      push_sweep();
      clr_pin_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ram_we && ram_addr == 7'd0, "R1", "first write after third edge",
          int'({ram_we, ram_addr}), 128);
      repeat (20) @(negedge clk);
      clr_pin_n = 1'b1;
      repeat (20) @(negedge clk);
      clr_pin_n = 1'b0;                 // second edge mid-sweep, R8
      repeat (10) @(negedge clk);
      host_write(3'b000);               // R7 write under lock
      chk(host_rdata == 3'b000, "R7", "rdata under lock", int'(host_rdata), 0);
      while (host_lock) @(negedge clk);
      chk(lock_cycles == RC, "R6", "lock length", lock_cycles, RC);
      chk(writes_seen == NB && exp_q.size() == 0, "R8", "write count",
          writes_seen, NB);
      chk(host_rdata == 3'b111, "R3", "flag set, enables kept (R7)", int'(host_rdata), 7);
      chk(irq_n == 1'b0, "R4", "irq_n on completion", int'(irq_n), 0);
      clr_pin_n = 1'b1;
      repeat (5) @(negedge clk);

      // R3 write 1 keeps flag; R2 disabled edge keeps flag
      host_write(3'b110);
      chk(host_rdata == 3'b110, "R3", "write 1 keeps flag", int'(host_rdata), 6);
      clr_pin_n = 1'b0;
      repeat (10) @(negedge clk);
      chk(writes_seen == NB && host_rdata == 3'b110, "R2", "disabled edge, flag kept",
          int'(host_rdata), 6);
      clr_pin_n = 1'b1;
      repeat (5) @(negedge clk);

      // R3/R4 clear flag
      host_write(3'b010);
      chk(host_rdata == 3'b010, "R3", "flag cleared", int'(host_rdata), 2);
      chk(irq_n == 1'b1, "R4", "irq_n released", int'(irq_n), 1);

      // R5 other source
      other_irq = 1'b1;
      @(negedge clk);
      chk(irq_n == 1'b0, "R5", "other source holds irq", int'(irq_n), 0);
      other_irq = 1'b0;
      @(negedge clk);
      chk(irq_n == 1'b1, "R5", "other source gone", int'(irq_n), 1);

      // R9 sweep with no supply
      supply_ok = 1'b0;
      host_write(3'b011);
      push_sweep();
      clr_pin_n = 1'b0;
      repeat (RC + 10) @(negedge clk);
      chk(writes_seen == 2 * NB, "R9", "sweep without supply", writes_seen, 2 * NB);
      chk(host_rdata == 3'b111, "R9", "flag without supply", int'(host_rdata), 7);
      chk(irq_n == 1'b1, "R9", "irq_n held high without supply", int'(irq_n), 1);
      supply_ok = 1'b1;
      @(negedge clk);
      chk(irq_n == 1'b0, "R4", "irq_n once supply returns", int'(irq_n), 0);
      clr_pin_n = 1'b1;
      host_write(3'b011);
      host_write(3'b111);
      chk(host_rdata == 3'b011, "R3", "write 1 cannot set flag", int'(host_rdata), 3);
      chk(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule